// File: doc/BRIEF.md
# Burst-Aware Frame Padder

This stage sits in front of a fixed-length transform engine. Samples come in on a valid/ready stream with an end-of-burst flag, and several packets of a set length make up one transform frame. While a burst is running, samples go straight through in the same cycle, and the output is cut into packets of the configured packet length with a last flag.

When a burst ends partway through a frame, the block stops taking input. It then sends zero-valued samples until the frame is complete, so the engine never keeps a partial frame that would corrupt the first frame of the next burst. The end-of-burst marker moves to the final padded packet, and the next burst starts on a clean frame boundary.

Frame length (a power of two) and packet length are run-time configuration inputs. They may only change while the stream is idle at a frame boundary. A synchronous clear drops any partial frame and leaves padding.

Top module: `frame_padder`

## Requirements
- R1: After reset the block is idle: with `s_valid` low, `m_valid` is low and `s_ready` equals `m_ready`. The first burst starts at frame position 0.
- R2: Outside padding, an accepted input sample appears on `m_data` in the same cycle, unchanged, and `s_ready` equals `m_ready`.
- R3: `m_last` is high on an output beat exactly when its position p in the frame satisfies p mod `cfg_pkt_len` = `cfg_pkt_len`-1. The last beat of a frame is therefore always a packet end.
- R4: If `s_eob` is accepted on a beat that is not the last of its frame, the remaining beats of that frame are sent with `m_valid` high and `m_data` = 0.
- R5: While padding is pending, `s_ready` is low.
- R6: `m_eob` is high only together with `m_last`, on the final beat of the frame in which the burst ended, exactly once per burst.
- R7: An `s_eob` on the last beat of a frame adds no padding. `m_eob` is high on that beat, and `s_ready` follows `m_ready` again from the next cycle.
- R8: The burst after a padded frame starts at frame position 0.
- R9: The frame length is 2^`cfg_frame_log2` with `cfg_frame_log2` in 4..12, and `cfg_pkt_len` divides it. A burst of n samples produces ceil(n/frame)·frame output beats.
- R10: While a padding beat is stalled by a low `m_ready`, it stays valid with zero data.
- R11: While `clr` is high, `m_valid` and `s_ready` are low. Clear discards any partial frame and ends padding, so the next sample is at frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of position and padding |
| cfg_frame_log2 | input | 4 | Log2 of frame length |
| cfg_pkt_len | input | 13 | Packet length in samples |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted |
| s_data | input | DATA_W | Input sample |
| s_eob | input | 1 | Input sample ends the burst |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Output sample, zero while padding |
| m_last | output | 1 | Last sample of an output packet |
| m_eob | output | 1 | Last sample of the burst's final frame |

## Verification
The bench builds the block with DATA_W=16 and MAX_FRAME_LOG2=12. That covers the full 4096-sample frame cut into 1024-sample packets, with a burst ending on the third packet. Random bursts over several frame and packet pairs, including a frame of a single packet, check packet cuts, padding length and where the end marker lands. Random backpressure is mixed with directed stalls and a clear during padding.

// File: rtl/fp_pkg.sv
package fp_pkg;
   typedef enum logic {
      ST_PASS = 1'b0,
      ST_PAD  = 1'b1
   } pad_state_e;
endpackage

// File: rtl/fp_position.sv
module fp_position #(
   parameter int MAX_FRAME_LOG2 = 12,
   localparam int LEN_W = MAX_FRAME_LOG2 + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [LEN_W-1:0] frame_len,
   input  logic [LEN_W-1:0] pkt_len,
   output logic             frame_end,
   output logic             pkt_end
);
   logic [LEN_W-1:0] samp_q;
   logic [LEN_W-1:0] pkt_q;
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   assign frame_end = (samp_q == frame_len - ONE);
   assign pkt_end   = (pkt_q == pkt_len - ONE) || frame_end;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         samp_q <= '0;
         pkt_q  <= '0;
      end else if (step) begin
         if (frame_end) begin
            samp_q <= '0;
            pkt_q  <= '0;
         end else begin
            samp_q <= samp_q + ONE;
            pkt_q  <= pkt_end ? '0 : pkt_q + ONE;
         end
      end
   end
endmodule

// File: rtl/fp_ctrl.sv
module fp_ctrl
   import fp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic beat,
   input  logic in_eob,
   input  logic frame_end,
   output logic padding
);
   pad_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_PASS: if (beat && in_eob && !frame_end) st_d = ST_PAD;
         ST_PAD:  if (beat && frame_end)            st_d = ST_PASS;
         default: st_d = ST_PASS;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) st_q <= ST_PASS;
      else               st_q <= st_d;
   end

   assign padding = (st_q == ST_PAD);
endmodule

// File: rtl/frame_padder.sv
module frame_padder #(
   parameter int DATA_W         = 32,
   parameter int MAX_FRAME_LOG2 = 12,
   localparam int LEN_W = MAX_FRAME_LOG2 + 1,
   localparam int LOG_W = $clog2(MAX_FRAME_LOG2 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [LOG_W-1:0]  cfg_frame_log2,
   input  logic [LEN_W-1:0]  cfg_pkt_len,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_eob,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [DATA_W-1:0] m_data,
   output logic              m_last,
   output logic              m_eob
);
   generate
      if (MAX_FRAME_LOG2 < 4 || MAX_FRAME_LOG2 > 16) begin : g_bad_frame
         $error("frame_padder: MAX_FRAME_LOG2 must lie in 4..16");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("frame_padder: DATA_W must be positive");
      end
   endgenerate

   logic [LEN_W-1:0] frame_len;
   logic             padding;
   logic             frame_end;
   logic             pkt_end;
   logic             beat;
   logic             active;

   assign frame_len = LEN_W'(1) << cfg_frame_log2;
   assign active    = !clr;
   assign m_valid   = active && (padding || s_valid);
   assign s_ready   = active && !padding && m_ready;
   assign m_data    = padding ? '0 : s_data;
   assign beat      = m_valid && m_ready;
   assign m_last    = m_valid && pkt_end;
   assign m_eob     = m_valid && frame_end && (padding || s_eob);

   fp_position #(.MAX_FRAME_LOG2(MAX_FRAME_LOG2)) u_pos (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .step      (beat),
      .frame_len (frame_len),
      .pkt_len   (cfg_pkt_len),
      .frame_end (frame_end),
      .pkt_end   (pkt_end)
   );

   fp_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .beat      (beat),
      .in_eob    (s_eob && !padding),
      .frame_end (frame_end),
      .padding   (padding)
   );
endmodule

// File: rtl/frame_padder_chk.sv
module frame_padder_chk #(
   parameter int DATA_W         = 32,
   parameter int MAX_FRAME_LOG2 = 12,
   localparam int LEN_W = MAX_FRAME_LOG2 + 1,
   localparam int LOG_W = $clog2(MAX_FRAME_LOG2 + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic [LOG_W-1:0]  cfg_frame_log2,
   input logic [LEN_W-1:0]  cfg_pkt_len,
   input logic              s_valid,
   input logic              s_ready,
   input logic [DATA_W-1:0] s_data,
   input logic              s_eob,
   input logic              m_valid,
   input logic              m_ready,
   input logic [DATA_W-1:0] m_data,
   input logic              m_last,
   input logic              m_eob
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
   logic [LEN_W-1:0] c_pkt, c_frame, flen;
   logic             pad_seen, beat;

   assign flen = ONE << cfg_frame_log2;
   assign beat = m_valid && m_ready;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         c_pkt <= '0; c_frame <= '0; pad_seen <= 1'b0;
      end else begin
         if (beat) begin
            c_pkt   <= m_last ? '0 : c_pkt + ONE;
            c_frame <= (c_frame + ONE == flen) ? '0 : c_frame + ONE;
         end
         if (s_valid && s_ready && s_eob && !m_eob) pad_seen <= 1'b1;
         else if (beat && m_eob)                    pad_seen <= 1'b0;
      end
   end

   AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |-> (m_valid && m_data == s_data)); // R2
   AST_LAST_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && m_last) |-> (c_pkt + ONE == cfg_pkt_len)); // R3
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_seen && !clr) |-> (m_valid && m_data == '0)); // R4
   AST_PAD_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && s_eob && !m_eob) |=> !s_ready); // R5
   AST_EOB_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      m_eob |-> m_last); // R6
   AST_EOB_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && m_eob) |-> (c_frame + ONE == flen)); // R6
   AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_frame_log2 >= LOG_W'(4) && int'(cfg_frame_log2) <= MAX_FRAME_LOG2
       && cfg_pkt_len != '0 && (flen % cfg_pkt_len) == '0)); // R9
   AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_seen && !clr && !m_ready) |=> (clr || (m_valid && m_data == '0))); // R10
   AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> (!m_valid && !s_ready)); // R11
endmodule

bind frame_padder frame_padder_chk #(
   .DATA_W(DATA_W), .MAX_FRAME_LOG2(MAX_FRAME_LOG2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_frame_log2(cfg_frame_log2),
   .cfg_pkt_len(cfg_pkt_len), .s_valid(s_valid), .s_ready(s_ready),
   .s_data(s_data), .s_eob(s_eob), .m_valid(m_valid), .m_ready(m_ready),
   .m_data(m_data), .m_last(m_last), .m_eob(m_eob)
);

// File: tb/frame_padder_test.sv
module frame_padder_test;
   localparam int CLK_PERIOD     = 10;
   localparam int DATA_W         = 16;
   localparam int MAX_FRAME_LOG2 = 12;
   localparam int LEN_W          = MAX_FRAME_LOG2 + 1;
   localparam int LOG_W          = $clog2(MAX_FRAME_LOG2 + 1);

   logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
   logic [LOG_W-1:0]  cfg_frame_log2 = LOG_W'(4);
   logic [LEN_W-1:0]  cfg_pkt_len = LEN_W'(4);
   logic              s_valid = 1'b0, s_eob = 1'b0, m_ready = 1'b0;
   logic [DATA_W-1:0] s_data = '0;
   logic              s_ready, m_valid, m_last, m_eob;
   logic [DATA_W-1:0] m_data;

   frame_padder #(.DATA_W(DATA_W), .MAX_FRAME_LOG2(MAX_FRAME_LOG2)) uut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_frame_log2(cfg_frame_log2),
      .cfg_pkt_len(cfg_pkt_len), .s_valid(s_valid), .s_ready(s_ready),
      .s_data(s_data), .s_eob(s_eob), .m_valid(m_valid), .m_ready(m_ready),
      .m_data(m_data), .m_last(m_last), .m_eob(m_eob)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, failures = 0, cyc = 0;
   int rdy_mode = 1;            // 0 random, 1 high, 2 low
   int fl = 16, pl = 4, pos = 0;
   int beats_out = 0, eob_out = 0;
   logic [DATA_W-1:0] exp_d[$];
   bit exp_l[$], exp_e[$], exp_p[$];

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
      case (rdy_mode)
         0: m_ready <= ($urandom_range(0, 3) != 0);
         1: m_ready <= 1'b1;
         default: m_ready <= 1'b0;
      endcase
   end

   function automatic void model_accept(logic [DATA_W-1:0] d, bit e);
      exp_d.push_back(d);
      exp_l.push_back((pos % pl) == pl - 1);
      exp_e.push_back(e && pos == fl - 1);
      exp_p.push_back(1'b0);
      pos = (pos == fl - 1) ? 0 : pos + 1;
      if (e && pos != 0) begin
         while (pos != 0) begin
            exp_d.push_back('0);
            exp_l.push_back((pos % pl) == pl - 1);
            exp_e.push_back(pos == fl - 1);
            exp_p.push_back(1'b1);
            pos = (pos == fl - 1) ? 0 : pos + 1;
         end
      end
   endfunction

   always @(negedge clk) begin
      if (rst_n && !clr) begin
         if (exp_d.size() > 0) begin
            chk(!s_ready, "R5", "s_ready during padding", s_ready, 0);
            chk(m_valid, "R4", "m_valid during padding", m_valid, 1);
         end
         if (s_valid && s_ready) model_accept(s_data, s_eob);
         if (m_valid && m_ready) begin
            beats_out++;
            if (m_eob) eob_out++;
            if (exp_d.size() == 0) begin
               chk(1'b0, "R2", "unexpected output beat", 1, 0);
            end else begin
               logic [DATA_W-1:0] d;
               bit l, e, p;
               d = exp_d.pop_front(); l = exp_l.pop_front();
               e = exp_e.pop_front(); p = exp_p.pop_front();
               chk(m_data == d, p ? "R4" : "R2", "m_data", int'(m_data), int'(d));
               chk(m_last == l, "R3", "m_last", m_last, l);
               chk(m_eob == e, (e && !p) ? "R7" : "R6", "m_eob", m_eob, e);
            end
         end
      end
   end

   task automatic send_beat(logic [DATA_W-1:0] d, bit e);
      s_data = d; s_eob = e; s_valid = 1'b1;
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #1;
      s_valid = 1'b0; s_eob = 1'b0;
      if (rdy_mode == 0) begin
         repeat ($urandom_range(0, 1)) @(posedge clk);
         #0;
      end
   endtask

   task automatic drain();
      while (exp_d.size() != 0) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic set_cfg(int lg, int p);
      cfg_frame_log2 = LOG_W'(lg); cfg_pkt_len = LEN_W'(p);
      fl = 1 << lg; pl = p; pos = 0;
   endtask

   task automatic send_burst(int n, string tag);
      int b0, e0;
      b0 = beats_out; e0 = eob_out;
      for (int i = 0; i < n; i++)
         send_beat(DATA_W'($urandom) | DATA_W'(1), i == n - 1);
      drain();
      chk(beats_out - b0 == ((n + fl - 1) / fl) * fl, tag, "beats per burst",
          beats_out - b0, ((n + fl - 1) / fl) * fl);
      chk(eob_out - e0 == 1, "R6", "eob count per burst", eob_out - e0, 1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      chk(m_valid == 1'b0, "R1", "m_valid in reset", m_valid, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(m_valid == 1'b0, "R1", "m_valid idle", m_valid, 0);
      chk(s_ready == m_ready, "R1", "s_ready follows m_ready", s_ready, m_ready);
      @(posedge clk); #1;

      // directed, 16-sample frames of 4-sample packets
      set_cfg(4, 4);
      send_burst(16, "R7");
      @(negedge clk);
      chk(s_ready == m_ready, "R7", "ready after boundary eob", s_ready, m_ready);
      @(posedge clk); #1;
      send_burst(10, "R4");
      send_burst(1, "R4");
      send_burst(4, "R8");
      send_burst(32, "R7");

      // stall during padding
      for (int i = 0; i < 3; i++) send_beat(DATA_W'(i + 5), i == 2);
      rdy_mode = 2;
      repeat (2) @(posedge clk);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(m_valid && m_data == '0 && !s_ready, "R10", "stalled pad beat",
             int'(m_data), 0);
      end
      @(posedge clk); #1;
      rdy_mode = 0;
      drain();

      // clear with a partial frame
      rdy_mode = 1;
      for (int i = 0; i < 5; i++) send_beat(DATA_W'(i + 1), 1'b0);
      drain();
      clr = 1'b1; s_valid = 1'b1; s_data = DATA_W'(7);
      @(negedge clk);
      chk(!m_valid && !s_ready, "R11", "outputs during clr", m_valid, 0);
      @(posedge clk); #1;
      clr = 1'b0; s_valid = 1'b0; pos = 0;
      send_burst(4, "R11");

      // clear during padding
      for (int i = 0; i < 3; i++) send_beat(DATA_W'(i + 9), i == 2);
      rdy_mode = 2;
      repeat (3) @(posedge clk);
      #1 clr = 1'b1;
      @(negedge clk);
      chk(!m_valid, "R11", "m_valid during clr", m_valid, 0);
      @(posedge clk); #1;
      clr = 1'b0;
      exp_d.delete(); exp_l.delete(); exp_e.delete(); exp_p.delete();
      pos = 0; rdy_mode = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(!m_valid && s_ready, "R11", "padding left after clr", s_ready, 1);
      @(posedge clk); #1;
      send_burst(6, "R11");

      // large frame, burst ends on third packet
      rdy_mode = 0;
      set_cfg(12, 1024);
      send_burst(3072, "R4");
      send_burst(4096, "R8");

      // random bursts over several configurations
      for (int k = 0; k < 40; k++) begin
         case ($urandom_range(0, 3))
            0: set_cfg(4, 4);
            1: set_cfg(6, 16);
            2: set_cfg(5, 32);
            default: set_cfg(7, 8);
         endcase
         send_burst($urandom_range(1, 3 * fl), "R9");
      end

      repeat (4) @(posedge clk);
      finish_run();
   end
endmodule